// File: doc/BRIEF.md
# Dual-Mode 4x4 / 8x8 Integer Block Transform

This block is a two-dimensional integer transform engine that takes and returns eight samples per clock. Each block is transformed in two passes. The row pass transforms each incoming beat as it arrives and writes it into a two-bank transpose store. Once a bank holds a whole block, the column pass reads it out one column per cycle, transforms that column and registers the result. The same datapath serves both mode decision, where forward transforms of residuals feed a cost measure, and reconstruction, where forward and inverse transforms are needed.

The shape and direction are chosen at run time. In 8x8 shape a block is eight beats, and each beat is one row of eight samples. In 4x4 shape a block is four beats. Lanes 0..3 carry one row of a first 4x4 block and lanes 4..7 carry the same row of a second, independent 4x4 block. Both 4x4 blocks are transformed together. The kernels are exact integer matrices with no rounding, so any normalising shift is left to the consumer.

Top module: `dual_xform8`

## Requirements
- R1: After synchronous reset `out_valid` is 0, and it stays 0 while no block has been supplied.
- R2: An 8x8 forward block X (input beat r, lane c = X[r][c]) produces Y = M·X·Mᵀ. M has these first four entries per row: row0 8 8 8 8, row1 12 10 6 3, row2 8 4 -4 -8, row3 10 -3 -12 -6, row4 8 -8 -8 8, row5 6 -12 3 10, row6 4 -8 8 -4, row7 3 -6 10 -12. Entries 4..7 mirror entries 3..0 on even rows and mirror them negated on odd rows.
- R3: An 8x8 inverse block uses Mᵀ in place of M, giving Y = Mᵀ·X·M.
- R4: A 4x4 forward beat pair of blocks uses the matrix with rows {1,1,1,1}, {2,1,-1,-2}, {1,-1,-1,1} and {1,-2,2,-1}. Each half, lanes 0..3 and lanes 4..7, is transformed on its own.
- R5: A 4x4 inverse block uses the matrix with rows {2,2,2,1}, {2,1,-2,-2}, {2,-1,-2,2} and {2,-2,2,-1}. This is twice the usual half-weight inverse, so no precision is lost.
- R6: Output beat k carries column k of Y. In 8x8 shape lane i holds Y[i][k]. In 4x4 shape lane i holds Y[i][k] of the first block and lane 4+i holds Y[i][k] of the second. In `in_data` lane i occupies bits [9i+8:9i] as two's complement. In `out_data` lane i occupies bits [23i+22:23i].
- R7: With beats supplied on consecutive cycles, the first result beat is registered L+1 rising edges after the edge that captured the first input beat (L = 8 or 4). The remaining L-1 beats follow on consecutive edges.
- R8: Blocks of one shape supplied back to back, with no idle cycles, produce back-to-back output with the same fixed latency for every block.
- R9: Shape (`in_8x8`) and direction (`in_inv`) are sampled on a block's first beat. Changes on later beats of that block have no effect on its result.
- R10: Every 9-bit signed input block, including all-extreme and sign-matched ±256/255 patterns, yields the exact mathematical result with no overflow.
- R11: A 4x4 block may follow an 8x8 block only after at least four idle cycles. Any other shape sequence may run back to back, and the latency of R7 holds across shape changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat present |
| in_8x8 | input | 1 | Shape of the block starting on this beat: 1 = 8x8, 0 = two 4x4 |
| in_inv | input | 1 | Direction of the block starting on this beat: 1 = inverse |
| in_data | input | 72 | Eight signed 9-bit samples |
| out_valid | output | 1 | Result beat present |
| out_data | output | 184 | Eight signed 23-bit results |

## Verification
The bench builds the block with its default 9-bit sample width. This keeps output lanes at 23 bits, so every expected value fits a plain integer in the bench. At that size it can sweep an impulse through all 64 positions of an 8x8 block in both directions. It also sweeps impulse pairs through every 4x4 position in both halves, which pins down every matrix coefficient and the lane-to-column mapping. Random blocks, extreme-value patterns, mid-block control changes and shape switches cover the throughput, latching and overflow corners.

// File: rtl/xf_pkg.sv
package xf_pkg;
  localparam int XF_LANES = 8;
  typedef enum logic {SHP_4X4 = 1'b0, SHP_8X8 = 1'b1} shape_e;
endpackage

// File: rtl/xf_pass.sv
// One-dimensional transform of eight lanes: two 4-point kernels or one
// 8-point kernel, forward or inverse. Pure adds and shifts.
module xf_pass
  import xf_pkg::*;
#(
  parameter int IW = 9,
  parameter int OW = 16
) (
  input  shape_e                shp,
  input  logic                  inv,
  input  logic signed [IW-1:0]  x [XF_LANES],
  output logic signed [OW-1:0]  y [XF_LANES]
);
  typedef logic signed [OW-1:0] w_t;

  function automatic w_t t3(input w_t a);  return (a <<< 1) + a;        endfunction
  function automatic w_t t6(input w_t a);  return (a <<< 2) + (a <<< 1); endfunction
  function automatic w_t t10(input w_t a); return (a <<< 3) + (a <<< 1); endfunction
  function automatic w_t t12(input w_t a); return (a <<< 3) + (a <<< 2); endfunction

  w_t v  [XF_LANES];
  w_t f4 [XF_LANES];
  w_t i4 [XF_LANES];
  w_t f8 [XF_LANES];
  w_t i8 [XF_LANES];

  always_comb begin
    for (int i = 0; i < XF_LANES; i++) v[i] = w_t'(x[i]);
  end

  // two 4-point kernels side by side
  always_comb begin
    for (int h = 0; h < 2; h++) begin
      w_t s0, s1, d0, d1, e, f, g, k;
      s0 = v[4*h]   + v[4*h+3];
      s1 = v[4*h+1] + v[4*h+2];
      d0 = v[4*h]   - v[4*h+3];
      d1 = v[4*h+1] - v[4*h+2];
      f4[4*h]   = s0 + s1;
      f4[4*h+1] = (d0 <<< 1) + d1;
      f4[4*h+2] = s0 - s1;
      f4[4*h+3] = d0 - (d1 <<< 1);
      e = (v[4*h] + v[4*h+2]) <<< 1;
      f = (v[4*h] - v[4*h+2]) <<< 1;
      g = v[4*h+1] - (v[4*h+3] <<< 1);
      k = (v[4*h+1] <<< 1) + v[4*h+3];
      i4[4*h]   = e + k;
      i4[4*h+1] = f + g;
      i4[4*h+2] = f - g;
      i4[4*h+3] = e - k;
    end
  end

  // 8-point forward butterfly
  always_comb begin
    w_t a0, a1, a2, a3, a4, a5, a6, a7, b0, b1, b2, b3;
    a0 = v[0] + v[7]; a1 = v[1] + v[6]; a2 = v[2] + v[5]; a3 = v[3] + v[4];
    a4 = v[0] - v[7]; a5 = v[1] - v[6]; a6 = v[2] - v[5]; a7 = v[3] - v[4];
    b0 = a0 + a3; b1 = a1 + a2; b2 = a0 - a3; b3 = a1 - a2;
    f8[0] = (b0 + b1) <<< 3;
    f8[4] = (b0 - b1) <<< 3;
    f8[2] = (b2 <<< 3) + (b3 <<< 2);
    f8[6] = (b2 <<< 2) - (b3 <<< 3);
    f8[1] = t12(a4) + t10(a5) + t6(a6) + t3(a7);
    f8[3] = t10(a4) - t3(a5) - t12(a6) - t6(a7);
    f8[5] = t6(a4) - t12(a5) + t3(a6) + t10(a7);
    f8[7] = t3(a4) - t6(a5) + t10(a6) - t12(a7);
  end

  // 8-point inverse butterfly (transposed kernel)
  always_comb begin
    w_t ev [4];
    w_t od [4];
    ev[0] = ((v[0] + v[4]) <<< 3) + (v[2] <<< 3) + (v[6] <<< 2);
    ev[1] = ((v[0] - v[4]) <<< 3) + (v[2] <<< 2) - (v[6] <<< 3);
    ev[2] = ((v[0] - v[4]) <<< 3) - (v[2] <<< 2) + (v[6] <<< 3);
    ev[3] = ((v[0] + v[4]) <<< 3) - (v[2] <<< 3) - (v[6] <<< 2);
    od[0] = t12(v[1]) + t10(v[3]) + t6(v[5]) + t3(v[7]);
    od[1] = t10(v[1]) - t3(v[3]) - t12(v[5]) - t6(v[7]);
    od[2] = t6(v[1]) - t12(v[3]) + t3(v[5]) + t10(v[7]);
    od[3] = t3(v[1]) - t6(v[3]) + t10(v[5]) - t12(v[7]);
    for (int j = 0; j < 4; j++) begin
      i8[j]   = ev[j] + od[j];
      i8[7-j] = ev[j] - od[j];
    end
  end

  always_comb begin
    for (int i = 0; i < XF_LANES; i++) begin
      if (shp == SHP_8X8) y[i] = inv ? i8[i] : f8[i];
      else                y[i] = inv ? i4[i] : f4[i];
    end
  end
endmodule

// File: rtl/xf_tbuf.sv
// Two-bank transpose store: rows written per beat, columns read per cycle.
module xf_tbuf
  import xf_pkg::*;
#(
  parameter int RW = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  wr_bank,
  input  logic [$clog2(XF_LANES)-1:0] wr_row,
  input  shape_e                wr_shp,
  input  logic signed [RW-1:0]  wr_data [XF_LANES],
  input  logic                  rd_bank,
  input  logic [$clog2(XF_LANES)-1:0] rd_col,
  input  shape_e                rd_shp,
  output logic signed [RW-1:0]  rd_data [XF_LANES]
);
  localparam int AW   = $clog2(XF_LANES);
  localparam int HALF = XF_LANES / 2;

  logic signed [RW-1:0] mem [2][XF_LANES][XF_LANES];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int c = 0; c < XF_LANES; c++) mem[wr_bank][wr_row][c] <= wr_data[c];
    end
  end

  always_comb begin
    for (int r = 0; r < XF_LANES; r++) begin
      if (rd_shp == SHP_8X8)
        rd_data[r] = mem[rd_bank][AW'(r)][rd_col];
      else if (r < HALF)
        rd_data[r] = mem[rd_bank][AW'(r)][{1'b0, rd_col[AW-2:0]}];
      else
        rd_data[r] = mem[rd_bank][AW'(r - HALF)][{1'b1, rd_col[AW-2:0]}];
    end
  end

  // R4: a 4x4 pair only ever fills the upper half of the row space
  a_r4_row_range: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_shp == SHP_4X4) |-> !wr_row[AW-1]);
endmodule

// File: rtl/dual_xform8.sv
module dual_xform8
  import xf_pkg::*;
#(
  parameter  int IN_W  = 9,
  localparam int OUT_W = IN_W + 14
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic                        in_8x8,
  input  logic                        in_inv,
  input  logic [XF_LANES*IN_W-1:0]    in_data,
  output logic                        out_valid,
  output logic [XF_LANES*OUT_W-1:0]   out_data
);
  localparam int ROW_W = IN_W + 7;
  localparam int AW    = $clog2(XF_LANES);

  logic signed [IN_W-1:0]  xin  [XF_LANES];
  logic signed [ROW_W-1:0] rowv [XF_LANES];
  logic signed [ROW_W-1:0] colin[XF_LANES];
  logic signed [OUT_W-1:0] colv [XF_LANES];

  logic [AW-1:0] wcnt, rcol;
  logic          wbank, rbank, rd_act, inv_q;
  shape_e        shp_q, cur_shp, rshp;
  logic          cur_inv, wlast, rlast, rd_done, cand, go;
  logic [1:0]    full, binv;
  shape_e        bshp [2];

  always_comb begin
    for (int i = 0; i < XF_LANES; i++) xin[i] = $signed(in_data[i*IN_W +: IN_W]);
  end

  // block control is sampled on the first beat only
  assign cur_shp = (wcnt == '0) ? shape_e'(in_8x8) : shp_q;
  assign cur_inv = (wcnt == '0) ? in_inv : inv_q;
  assign wlast   = (cur_shp == SHP_8X8) ? (wcnt == AW'(XF_LANES - 1))
                                        : (wcnt == AW'(XF_LANES / 2 - 1));

  assign rshp    = bshp[rbank];
  assign rlast   = (rshp == SHP_8X8) ? (rcol == AW'(XF_LANES - 1))
                                     : (rcol == AW'(XF_LANES / 2 - 1));
  assign rd_done = rd_act && rlast;
  assign cand    = rd_done ? ~rbank : rbank;
  assign go      = (!rd_act || rd_done) && full[cand];

  xf_pass #(.IW(IN_W), .OW(ROW_W)) u_row (
    .shp(cur_shp), .inv(cur_inv), .x(xin), .y(rowv));

  xf_tbuf #(.RW(ROW_W)) u_buf (
    .clk(clk), .rst(rst),
    .wr_en(in_valid), .wr_bank(wbank), .wr_row(wcnt), .wr_shp(cur_shp), .wr_data(rowv),
    .rd_bank(rbank), .rd_col(rcol), .rd_shp(rshp), .rd_data(colin));

  xf_pass #(.IW(ROW_W), .OW(OUT_W)) u_col (
    .shp(rshp), .inv(binv[rbank]), .x(colin), .y(colv));

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt   <= '0;
      wbank  <= 1'b0;
      shp_q  <= SHP_4X4;
      inv_q  <= 1'b0;
      full   <= '0;
      binv   <= '0;
      bshp[0] <= SHP_4X4;
      bshp[1] <= SHP_4X4;
      rd_act <= 1'b0;
      rbank  <= 1'b0;
      rcol   <= '0;
    end else begin
      if (in_valid) begin
        wcnt <= wlast ? '0 : wcnt + 1'b1;
        if (wcnt == '0) begin
          shp_q <= cur_shp;
          inv_q <= cur_inv;
        end
        if (wlast) wbank <= ~wbank;
      end
      if (rd_done) full[rbank] <= 1'b0;
      if (in_valid && wlast) begin
        full[wbank] <= 1'b1;
        bshp[wbank] <= cur_shp;
        binv[wbank] <= cur_inv;
      end
      rbank <= cand;
      if (go) begin
        rd_act <= 1'b1;
        rcol   <= '0;
      end else if (rd_done) begin
        rd_act <= 1'b0;
      end else if (rd_act) begin
        rcol <= rcol + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= rd_act;
    for (int i = 0; i < XF_LANES; i++) out_data[i*OUT_W +: OUT_W] <= colv[i];
  end

  // R8: the column pass only ever reads a completely written bank
  a_r8_read_full: assert property (@(posedge clk) disable iff (rst)
    rd_act |-> full[rbank]);

  // R11: a bank still awaiting readout is written only as its last column leaves
  a_r11_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    (in_valid && full[wbank]) |-> (rd_done && rbank == wbank));

  // R6: a 4x4 pair is read out in four columns
  a_r6_col_range: assert property (@(posedge clk) disable iff (rst)
    (rd_act && rshp == SHP_4X4) |-> !rcol[AW-1]);
endmodule

// File: tb/dual_xform8_test.sv
module dual_xform8_test;
  localparam int W  = 9;
  localparam int OW = W + 14;
  localparam int NL = 8;
  localparam int NBMAX = 256;

  localparam int F8H [8][4] = '{'{8,8,8,8}, '{12,10,6,3}, '{8,4,-4,-8}, '{10,-3,-12,-6},
                                '{8,-8,-8,8}, '{6,-12,3,10}, '{4,-8,8,-4}, '{3,-6,10,-12}};
  localparam int F4 [4][4] = '{'{1,1,1,1}, '{2,1,-1,-2}, '{1,-1,-1,1}, '{1,-2,2,-1}};
  localparam int I4 [4][4] = '{'{2,2,2,1}, '{2,1,-2,-2}, '{2,-1,-2,2}, '{2,-2,2,-1}};

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, in_8x8 = 1'b0, in_inv = 1'b0;
  logic [NL*W-1:0]  in_data = '0;
  logic             out_valid;
  logic [NL*OW-1:0] out_data;

  dual_xform8 #(.IN_W(W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_8x8(in_8x8), .in_inv(in_inv),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  int xin [8][8];
  int ey [NBMAX][8][8];
  int elen [NBMAX];
  int estart [NBMAX];
  string etag [NBMAX];
  int nb = 0, ob = 0, obeat = 0;
  bit prev8 = 0;
  bit bad = 0;
  int m_lane, m_beat, m_act, m_exp;

  function automatic int f8c(int i, int j);
    if (j < 4) return F8H[i][j];
    if (i % 2 == 0) return F8H[i][7-j];
    return -F8H[i][7-j];
  endfunction

  function automatic int mc(bit is8, bit inv, int i, int j);
    if (is8) return inv ? f8c(j, i) : f8c(i, j);
    return inv ? I4[i][j] : F4[i][j];
  endfunction

  task automatic send(bit is8, bit inv, string tag, bit scramble);
    int n;
    n = is8 ? 8 : 4;
    if (prev8 && !is8) begin   // R11 spacing rule
      repeat (4) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
    end
    for (int k = 0; k < n; k++) begin
      for (int lane = 0; lane < NL; lane++) begin
        int s, h, i, sz;
        s = 0;
        sz = is8 ? 8 : 4;
        h = is8 ? 0 : lane / 4;
        i = is8 ? lane : lane % 4;
        for (int r = 0; r < sz; r++)
          for (int c = 0; c < sz; c++)
            s += mc(is8, inv, i, r) * xin[r][4*h + c] * mc(is8, inv, k, c);
        ey[nb][k][lane] = s;
      end
    end
    elen[nb] = n;
    etag[nb] = tag;
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      if (b == 0) estart[nb] = cyc;
      in_valid = 1'b1;
      in_8x8 = (b == 0 || !scramble) ? is8 : ~is8;   // R9 disturbance
      in_inv = (b == 0 || !scramble) ? inv : ~inv;
      for (int c = 0; c < NL; c++) in_data[c*W +: W] = W'(xin[b][c]);
    end
    nb++;
    prev8 = is8;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_8x8 = ~in_8x8;
  endtask

  task automatic clear();
    for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) xin[r][c] = 0;
  endtask

  task automatic randfill();
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) xin[r][c] = int'($urandom_range(511)) - 256;
  endtask

  // result monitor: R6 data, R7 latency, R8 continuity
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (ob >= nb) begin
        checks++; errors++;
        $display("FAIL R7 spurious output beat: actual valid=1 expected valid=0");
      end else begin
        if (obeat == 0) begin
          checks++;
          if (cyc - estart[ob] != elen[ob] + 2) begin
            errors++;
            $display("FAIL R7 %s block %0d latency actual %0d expected %0d",
                     etag[ob], ob, cyc - estart[ob], elen[ob] + 2);
          end
        end
        if (cyc != estart[ob] + elen[ob] + 2 + obeat && !bad) begin
          bad = 1; m_lane = -1; m_beat = obeat;
          m_act = cyc; m_exp = estart[ob] + elen[ob] + 2 + obeat;
        end
        for (int lane = 0; lane < NL; lane++) begin
          int v;
          v = int'($signed(out_data[lane*OW +: OW]));
          if (v != ey[ob][obeat][lane] && !bad) begin
            bad = 1; m_lane = lane; m_beat = obeat; m_act = v; m_exp = ey[ob][obeat][lane];
          end
        end
        if (obeat == elen[ob] - 1) begin
          checks++;
          if (bad) begin
            errors++;
            $display("FAIL R6 %s block %0d beat %0d lane %0d actual %0d expected %0d",
                     etag[ob], ob, m_beat, m_lane, m_act, m_exp);
          end
          bad = 0; obeat = 0; ob++;
        end else begin
          obeat++;
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: quiet after reset
    repeat (6) begin
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
        errors++;
        $display("FAIL R1 out_valid actual %b expected 0", out_valid);
      end
    end
    // R2 / R3: impulse at every 8x8 position
    for (int d = 0; d < 2; d++)
      for (int p = 0; p < 64; p++) begin
        clear();
        xin[p/8][p%8] = (p % 2) ? -(p + 3) : (3*p + 1);
        send(1'b1, d[0], d ? "R3" : "R2", 1'b0);
      end
    // R4 / R5: impulse pair walking through both 4x4 halves
    for (int d = 0; d < 2; d++)
      for (int p = 0; p < 16; p++) begin
        clear();
        xin[p/4][p%4] = (p % 2) ? -5*(p + 1) : 5*(p + 1);
        xin[(15-p)/4][4 + (15-p)%4] = 200 - p;
        send(1'b0, d[0], d ? "R5" : "R4", 1'b0);
      end
    // R8: back-to-back random blocks of one shape
    for (int b = 0; b < 12; b++) begin randfill(); send(1'b1, b[0], "R8", 1'b0); end
    for (int b = 0; b < 12; b++) begin randfill(); send(1'b0, b[0], "R8", 1'b0); end
    // R9: control toggled on every later beat of a block
    for (int b = 0; b < 4; b++) begin randfill(); send(b[1], b[0], "R9", 1'b1); end
    // R10: extreme values
    for (int d = 0; d < 2; d++) begin
      for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) xin[r][c] = 255;
      send(1'b1, d[0], "R10", 1'b0);
      for (int r = 0; r < 8; r++) for (int c = 0; c < 8; c++) xin[r][c] = -256;
      send(1'b1, d[0], "R10", 1'b0);
      for (int r = 0; r < 8; r++)
        for (int c = 0; c < 8; c++)
          xin[r][c] = (f8c(1, r) * f8c(1, c) >= 0) ? 255 : -256;
      send(1'b1, d[0], "R10", 1'b0);
      for (int r = 0; r < 8; r++)
        for (int c = 0; c < 8; c++)
          xin[r][c] = (F4[1][r%4] * F4[1][c%4] >= 0) ? 255 : -256;
      send(1'b0, d[0], "R10", 1'b0);
    end
    // R11: shape changes in both directions
    for (int b = 0; b < 6; b++) begin randfill(); send(b[0], b[1], "R11", 1'b0); end
    idle();
    repeat (4) idle();
    while (ob < nb && cyc < 150000) @(negedge clk);
    if (ob < nb) begin
      checks++; errors++;
      $display("FAIL R7 watchdog: blocks returned actual %0d expected %0d", ob, nb);
    end
    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule